// File: doc/BRIEF.md
# Crystal Settle-Time Status Counter

This block counts edges of an external crystal clock after the oscillator has been released. Progress is shown as a status byte that fills from the most significant bit downward as the count passes five power-of-two thresholds, which are not evenly spaced. Software reads the byte to judge whether the crystal has run long enough to be trusted before it moves the CPU onto that clock.

A 3-bit select picks the target threshold. The count stops there, so levels beyond the target never appear. A completion flag rises when the selected level is reached. The status returns to zero on a synchronous reset, on a STOP-entry pulse, and for as long as the oscillator-off control is held. A second copy of the byte is passed through two flops into the reader's clock domain. Each bit only ever moves from 0 to 1 between clears, so capturing several bits at once cannot produce a code that never existed.

The block has no data stream, so it uses no valid/ready handshake. All pins are plain control and status levels.

Top module: `osc_settle_status`

## Requirements
- R1: After `xrst` the status byte reads 00h. Bits 2 to 0 of `status` always read 0.
- R2: With base exponent B (11 by default), the five levels have thresholds 2^B, 2^(B+2), 2^(B+3), 2^(B+4) and 2^(B+5) crystal edges. Level i is shown in `status` bit 7-i. Level i becomes 1 at the k-th counting edge once k reaches its threshold.
- R3: The levels form a thermometer code. A bit in `status[7:3]` is never 1 while a bit above it is 0.
- R4: Once a level bit is set it stays at 1 until a clear condition occurs, even when `tsel` is lowered.
- R5: A one-cycle `stop_req` pulse clears `status` to 00h at that crystal edge.
- R6: While `osc_off` is 1, `status` stays 00h and counting does not advance.
- R7: `tsel` values 0 to 4 select levels 0 to 4, and values 5 to 7 select level 4. Levels above the selected one are never set. The count holds at the selected threshold, and raising `tsel` later resumes counting from that held value.
- R8: `done` is 1 exactly when the level bit for the current `tsel` is set.
- R9: Counting starts from zero. The first crystal edge with no clear condition active gives a count of 1.
- R10: `rstatus` presents `status` in the `rclk` domain after two `rclk` edges. It is 00h while `rrst` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xclk | input | 1 | Crystal clock |
| xrst | input | 1 | Synchronous reset, crystal domain |
| stop_req | input | 1 | STOP-mode entry pulse; clears the status |
| osc_off | input | 1 | Oscillator-off control level; holds the status clear |
| tsel | input | 3 | Target level select |
| status | output | 8 | Status byte, crystal domain |
| done | output | 1 | Selected level reached |
| rclk | input | 1 | Reader clock |
| rrst | input | 1 | Synchronous reset, reader domain |
| rstatus | output | 8 | Status byte synchronized to rclk |

## Verification
The bench uses a small base exponent. For every `tsel` value it clears the block and walks the count edge by edge past the top threshold. This separates off-by-one errors at each threshold, wrong bit positions, and the handling of the out-of-range selects. A count held at the lowest target and then released by raising `tsel` shows whether the count saturates or keeps running. Lowering `tsel` afterwards shows whether set bits are sticky. STOP pulses and held oscillator-off periods in the middle of a run check the clear paths and the restart from zero. Reads on the slower reader clock, taken after the status has settled, check the synchronized copy and its own reset.

// File: rtl/oss_pkg.sv
package oss_pkg;
  localparam int unsigned NLVL  = 5;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned LVL_W = $clog2(NLVL);

  // exponent of level i: base, then base+2 .. base+5
  function automatic int unsigned lvl_exp(int unsigned base, int unsigned i);
    return (i == 0) ? base : base + i + 1;
  endfunction
endpackage

// File: rtl/oss_sel_decode.sv
module oss_sel_decode
  import oss_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11,
  parameter int unsigned CNT_W    = BASE_EXP + 6
) (
  input  logic [SEL_W-1:0] tsel,
  output logic [LVL_W-1:0] lvl,
  output logic [CNT_W-1:0] target
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(NLVL - 1);

  always_comb begin
    lvl = (tsel > SEL_W'(NLVL - 1)) ? TOP : LVL_W'(tsel);
    target = '0;
    for (int i = 0; i < int'(NLVL); i++) begin
      if (lvl == LVL_W'(i))
        target = CNT_W'(1) << lvl_exp(BASE_EXP, i);
    end
  end
endmodule

// File: rtl/oss_count.sv
module oss_count #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run = (cnt_q < target);

  always_comb begin
    if (clr)      cnt_nxt = '0;
    else if (run) cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) cnt_q <= cnt_nxt;
endmodule

// File: rtl/oss_therm.sv
module oss_therm
  import oss_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11,
  parameter int unsigned CNT_W    = BASE_EXP + 6
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [LVL_W-1:0] lvl,
  output logic [NLVL-1:0]  lvls
);
  for (genvar i = 0; i < int'(NLVL); i++) begin : g_lvl
    localparam logic [CNT_W-1:0] THR = CNT_W'(1) << lvl_exp(BASE_EXP, i);
    logic hit;
    assign hit = (LVL_W'(i) <= lvl) && (cnt_nxt >= THR);
    always_ff @(posedge clk) begin
      if (clr) lvls[i] <= 1'b0;
      else     lvls[i] <= lvls[i] | hit;
    end
  end
endmodule

// File: rtl/oss_sync.sv
module oss_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/osc_settle_status.sv
module osc_settle_status
  import oss_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11
) (
  input  logic              xclk,
  input  logic              xrst,
  input  logic              stop_req,
  input  logic              osc_off,
  input  logic [SEL_W-1:0]  tsel,
  output logic [BYTE_W-1:0] status,
  output logic              done,
  input  logic              rclk,
  input  logic              rrst,
  output logic [BYTE_W-1:0] rstatus
);
  localparam int unsigned CNT_W = BASE_EXP + 6;

  logic             clr;
  logic [LVL_W-1:0] lvl;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt_nxt;
  logic [NLVL-1:0]  lvls;

  assign clr = xrst | stop_req | osc_off;

  oss_sel_decode #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_dec (
    .tsel(tsel), .lvl(lvl), .target(target)
  );

  oss_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(xclk), .clr(clr), .target(target), .cnt_nxt(cnt_nxt)
  );

  oss_therm #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_therm (
    .clk(xclk), .clr(clr), .cnt_nxt(cnt_nxt), .lvl(lvl), .lvls(lvls)
  );

  // level 0 sits in the top bit, lower bits stay zero
  always_comb begin
    status = '0;
    for (int i = 0; i < int'(NLVL); i++) status[BYTE_W-1-i] = lvls[i];
  end

  assign done = lvls[lvl];

  oss_sync #(.W(BYTE_W)) u_sync (
    .clk(rclk), .rst(rrst), .d(status), .q(rstatus)
  );
endmodule

// File: rtl/osc_settle_status_chk.sv
module osc_settle_status_chk (
  input logic       xclk,
  input logic       xrst,
  input logic       stop_req,
  input logic       osc_off,
  input logic [2:0] tsel,
  input logic [7:0] status,
  input logic       done
);
  logic [2:0] sel_lvl;
  logic [4:0] v;
  assign sel_lvl = (tsel > 3'd4) ? 3'd4 : tsel;
  assign v = status[7:3];

  assert_low_zero_R1: assert property (@(posedge xclk) disable iff (xrst)
    status[2:0] == 3'b000);

  assert_thermo_R3: assert property (@(posedge xclk) disable iff (xrst)
    (v[3:0] & ~v[4:1]) == 4'b0000);

  assert_sticky_R4: assert property (@(posedge xclk) disable iff (xrst)
    (!stop_req && !osc_off) |=> ((status & $past(status)) == $past(status)));

  assert_clear_R5: assert property (@(posedge xclk) disable iff (xrst)
    (stop_req || osc_off) |=> (status == 8'h00));

  assert_done_R8: assert property (@(posedge xclk) disable iff (xrst)
    done |-> status[7]);

  for (genvar i = 0; i < 5; i++) begin : g_ov
    assert_no_overshoot_R7: assert property (@(posedge xclk) disable iff (xrst)
      (status[7-i] && !$past(status[7-i])) |-> ($past(sel_lvl) >= 3'(i)));
  end
endmodule

bind osc_settle_status osc_settle_status_chk u_chk (
  .xclk(xclk), .xrst(xrst), .stop_req(stop_req), .osc_off(osc_off),
  .tsel(tsel), .status(status), .done(done)
);

// File: tb/osc_settle_status_test.sv
module osc_settle_status_test;
  localparam int B = 3;

  logic       xclk = 0, rclk = 0;
  logic       xrst, rrst, stop_req, osc_off;
  logic [2:0] tsel;
  logic [7:0] status, rstatus;
  logic       done;
  int checks = 0, errors = 0;

  always #2 xclk = ~xclk;
  always #3.5 rclk = ~rclk;

  osc_settle_status #(.BASE_EXP(B)) uut (
    .xclk(xclk), .xrst(xrst), .stop_req(stop_req), .osc_off(osc_off),
    .tsel(tsel), .status(status), .done(done),
    .rclk(rclk), .rrst(rrst), .rstatus(rstatus)
  );

  function automatic int thr(int i);
    return 1 << ((i == 0) ? B : B + i + 1);
  endfunction

  function automatic int lvl_of(int sel);
    return (sel > 4) ? 4 : sel;
  endfunction

  function automatic logic [7:0] expv(int k, int sel);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < 5; i++)
      if (i <= lvl_of(sel) && k >= thr(i)) r[7-i] = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic step(); @(negedge xclk); endtask

  task automatic restart(int sel);
    step(); osc_off = 1; tsel = 3'(sel);
    step(); osc_off = 0;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e;
    xrst = 1; rrst = 1; stop_req = 0; osc_off = 0; tsel = 3'd0;
    repeat (4) step();
    chk("R1 reset", status, 8'h00);
    chk("R10 read reset", rstatus, 8'h00);
    chk("R8 done at reset", {7'b0, done}, 8'h00);
    rrst = 0;
    step(); xrst = 0;

    // R2 R3 R7 R8 R9: sweep every select
    for (int sel = 0; sel < 8; sel++) begin
      restart(sel);
      chk("R9 cleared before count", status, 8'h00);
      for (int k = 1; k <= thr(4) + 20; k++) begin
        step();
        e = expv(k, sel);
        chk($sformatf("R2 R3 R7 sel=%0d k=%0d", sel, k), status, e);
        chk($sformatf("R8 done sel=%0d k=%0d", sel, k), {7'b0, done},
            {7'b0, e[7-lvl_of(sel)]});
      end
    end

    // R10: settled status seen on read side
    repeat (4) @(negedge rclk);
    chk("R10 synchronized copy", rstatus, 8'hF8);
    rrst = 1; @(negedge rclk); @(negedge rclk);
    chk("R10 read reset clears", rstatus, 8'h00);
    rrst = 0;

    // R7: hold at lowest target, then raise select
    restart(0);
    for (int k = 1; k <= 40; k++) step();
    chk("R7 saturated at level 0", status, 8'h80);
    tsel = 3'd4;
    for (int m = 1; m <= thr(4); m++) begin
      step();
      chk($sformatf("R7 resume m=%0d", m), status, expv(thr(0) + m, 4));
    end
    // R4: lowering select keeps bits
    tsel = 3'd0;
    repeat (5) step();
    chk("R4 sticky after lowering select", status, 8'hF8);
    chk("R8 done follows select", {7'b0, done}, 8'h01);

    // R5 R9: STOP pulse mid-run and restart
    restart(2);
    for (int k = 1; k <= 40; k++) step();
    chk("R5 before stop", status, expv(40, 2));
    stop_req = 1; step(); stop_req = 0;
    chk("R5 stop clears", status, 8'h00);
    for (int k = 1; k <= thr(2) + 3; k++) begin
      step();
      chk($sformatf("R9 restart k=%0d", k), status, expv(k, 2));
    end

    // R6: oscillator off held
    osc_off = 1;
    for (int k = 0; k < 20; k++) begin
      step();
      chk("R6 held off", status, 8'h00);
    end
    osc_off = 0;
    for (int k = 1; k <= thr(0); k++) step();
    chk("R6 R9 count after release", status, 8'h80);

    // R1: reset mid-run
    xrst = 1; step(); xrst = 0;
    chk("R1 reset mid-run", status, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule